// File: doc/BRIEF.md
# Machine/User Privilege CSR Controller

This block holds the privilege state of a core that has only two operating levels, machine and user. It decodes a small CSR read/write port and serves the control registers that user-level execution needs: the machine ISA word, the status register's previous-mode and modify-privilege bits, the counter-enable register, the environment-configuration pair, the security-configuration bits and read-only user copies of the cycle and retired-instruction counters. The counters themselves are kept outside the block and arrive as 64-bit values.

The pipeline signals trap entry, ECALL and return-from-trap to the block. On a trap it switches to machine level, requests a flush and reports the ECALL cause code. On a return it restores the saved level. The block also gives the privilege level that loads and stores must use. CSR reads are combinational. Writes take effect at the next clock edge. An access that the current level may not make raises an illegal flag, returns zero and changes no state.

Top module: `priv_csr_ctrl`

## Requirements
- R1: After reset the level is machine (`priv_mode` = 2'b11). The status register reads 0x0000_1800, which is MPP = 2'b11 and modify-privilege clear. Counter-enable and security-configuration read as zero.
- R2: Address 0x301 reads 0x4010_0100, in which bit 20 (user level supported) is set. A write in machine level is accepted and changes nothing.
- R3: Status register (0x300): MPP sits in bits 12:11 and reads 2'b11 for machine or 2'b00 for user. A write of 2'b11 selects machine and any other value selects user. Bit 17 is the writable modify-privilege bit. Every other bit reads zero.
- R4: `trap_take` or `ecall` counts as trap entry. `flush_req` rises in the same cycle. At the next edge the level becomes machine and MPP takes the level that was active before the trap.
- R5: A `mret` in machine level with no trap in the same cycle loads the level from MPP and sets MPP to user. A `mret` in user level is ignored. Trap entry wins over a `mret` in the same cycle.
- R6: When `ecall` is high, `trap_cause` is 11 in machine level and 8 in user level. Otherwise it is 0.
- R7: Addresses 0x30A and 0x31A always read zero, and writes to them have no effect.
- R8: Addresses 0xC00, 0xC80, 0xC02 and 0xC82 return cycle[31:0], cycle[63:32], instret[31:0] and instret[63:32]. Any write to an address 0xCxx is illegal.
- R9: Counter-enable (0x306) stores bits 0 and 2 only. Bit 0 allows user reads of 0xC00/0xC80 and bit 2 allows user reads of 0xC02/0xC82. A user read without the bit set is illegal.
- R10: A user access to an address whose bits 9:8 are non-zero, or any access to an unimplemented address, is illegal. An illegal access returns zero and changes no register.
- R11: Security configuration (0x747) has writable bits 0, 1 and 2, and all its other bits read zero. 0x757 always reads zero.
- R12: `data_priv` equals MPP when the modify-privilege bit is set, and the current level otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req | input | 1 | CSR access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data |
| trap_take | input | 1 | Trap entry strobe |
| ecall | input | 1 | ECALL trap strobe |
| mret | input | 1 | Return-from-trap strobe |
| cycle_cnt | input | 64 | Machine cycle counter value |
| instret_cnt | input | 64 | Machine retired-instruction counter value |
| priv_mode | output | 2 | Current level, 2'b11 machine, 2'b00 user |
| data_priv | output | 2 | Level for loads and stores |
| csr_rdata | output | 32 | Read data |
| csr_illegal | output | 1 | Access not permitted |
| trap_cause | output | 4 | ECALL cause code |
| flush_req | output | 1 | Pipeline flush request |

## Verification
The assertions check on every cycle the behaviours that follow a single strobe or access: the switch to machine level and the capture of MPP on trap entry, the restore on return, a user `mret` being ignored, and the illegal flag with zero data for user accesses to machine registers and for counter writes. They also check that the configuration pair reads zero and that the level never changes without a strobe. Only the bench's scenarios can show the effects that span several cycles. These include the counter-enable gating after the register was written in machine level, a user write to counter-enable that must leave it unchanged, the MPP history across nested ECALLs, and the effective data level after a status write.

// File: rtl/priv_csr_ctrl.sv
module priv_csr_ctrl #(
  parameter logic [31:0] MISA_VAL = 32'h4010_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_req,
  input  logic        csr_we,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  input  logic        trap_take,
  input  logic        ecall,
  input  logic        mret,
  input  logic [63:0] cycle_cnt,
  input  logic [63:0] instret_cnt,
  output logic [1:0]  priv_mode,
  output logic [1:0]  data_priv,
  output logic [31:0] csr_rdata,
  output logic        csr_illegal,
  output logic [3:0]  trap_cause,
  output logic        flush_req
);
  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_MISA     = 12'h301;
  localparam logic [11:0] A_MCNTEN   = 12'h306;
  localparam logic [11:0] A_ENVLO    = 12'h30A;
  localparam logic [11:0] A_ENVHI    = 12'h31A;
  localparam logic [11:0] A_SECLO    = 12'h747;
  localparam logic [11:0] A_SECHI    = 12'h757;
  localparam logic [11:0] A_CYC      = 12'hC00;
  localparam logic [11:0] A_INS      = 12'hC02;
  localparam logic [11:0] A_CYCH     = 12'hC80;
  localparam logic [11:0] A_INSH     = 12'hC82;

  logic       user_q, mpp_inv_q, mprv_q, cy_en_q, ir_en_q;
  logic [2:0] sec_q;
  logic       hit, cnt_acc, gate;
  logic [31:0] rval;

  wire trap_in = trap_take | ecall;
  wire mret_ok = mret & ~user_q & ~trap_in;
  wire [1:0] mpp = {2{~mpp_inv_q}};

  always_comb begin
    hit = 1'b1; cnt_acc = 1'b0; gate = 1'b0; rval = '0;
    case (csr_addr)
      A_MSTATUS: rval = {14'b0, mprv_q, 4'b0, mpp, 11'b0};
      A_MISA:    rval = MISA_VAL;
      A_MCNTEN:  rval = {29'b0, ir_en_q, 1'b0, cy_en_q};
      A_ENVLO, A_ENVHI, A_SECHI: rval = '0;
      A_SECLO:   rval = {29'b0, sec_q};
      A_CYC:     begin rval = cycle_cnt[31:0];    cnt_acc = 1'b1; gate = cy_en_q; end
      A_CYCH:    begin rval = cycle_cnt[63:32];   cnt_acc = 1'b1; gate = cy_en_q; end
      A_INS:     begin rval = instret_cnt[31:0];  cnt_acc = 1'b1; gate = ir_en_q; end
      A_INSH:    begin rval = instret_cnt[63:32]; cnt_acc = 1'b1; gate = ir_en_q; end
      default:   hit = 1'b0;
    endcase
  end

  assign csr_illegal = csr_req & (~hit | (csr_we & (csr_addr[11:10] == 2'b11)) |
                       (user_q & (csr_addr[9:8] != 2'b00)) |
                       (user_q & cnt_acc & ~gate));
  assign csr_rdata = (csr_req & ~csr_illegal) ? rval : '0;
  wire wr = csr_req & csr_we & ~csr_illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q <= 1'b0; mpp_inv_q <= 1'b0; mprv_q <= 1'b0;
      cy_en_q <= 1'b0; ir_en_q <= 1'b0; sec_q <= '0;
    end else begin
      if (wr) begin
        case (csr_addr)
          A_MSTATUS: begin
            mpp_inv_q <= ~(csr_wdata[12] & csr_wdata[11]);
            mprv_q    <= csr_wdata[17];
          end
          A_MCNTEN: begin cy_en_q <= csr_wdata[0]; ir_en_q <= csr_wdata[2]; end
          A_SECLO:  sec_q <= csr_wdata[2:0];
          default: ;
        endcase
      end
      if (trap_in) begin
        user_q    <= 1'b0;
        mpp_inv_q <= user_q;
      end else if (mret_ok) begin
        user_q    <= mpp_inv_q;
        mpp_inv_q <= 1'b1;
      end
    end
  end

  assign priv_mode  = user_q ? 2'b00 : 2'b11;
  assign data_priv  = mprv_q ? mpp : priv_mode;
  assign trap_cause = ecall ? (user_q ? 4'd8 : 4'd11) : 4'd0;
  assign flush_req  = trap_in;
endmodule

// File: rtl/priv_csr_ctrl_chk.sv
module priv_csr_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_req,
  input logic        csr_we,
  input logic [11:0] csr_addr,
  input logic        trap_take,
  input logic        ecall,
  input logic        mret,
  input logic [1:0]  priv_mode,
  input logic [1:0]  data_priv,
  input logic [31:0] csr_rdata,
  input logic        csr_illegal,
  input logic [3:0]  trap_cause,
  input logic        mpp_inv_q
);
  a_r4_trap_to_machine: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take || ecall) |=> (priv_mode == 2'b11) && (mpp_inv_q == ($past(priv_mode) == 2'b00)));

  a_r5_mret_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && priv_mode == 2'b11 && !trap_take && !ecall) |=>
      (priv_mode == ($past(mpp_inv_q) ? 2'b00 : 2'b11)) && mpp_inv_q);

  a_r5_user_mret_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && priv_mode == 2'b00 && !trap_take && !ecall) |=> priv_mode == 2'b00);

  a_r5_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!mret && !trap_take && !ecall) |=> $stable(priv_mode));

  a_r6_ecall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ecall |-> (trap_cause == ((priv_mode == 2'b11) ? 4'd11 : 4'd8)));

  a_r7_envcfg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && (csr_addr == 12'h30A || csr_addr == 12'h31A)) |-> csr_rdata == 32'd0);

  a_r8_counter_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_we && csr_addr[11:8] == 4'hC) |-> csr_illegal);

  a_r10_user_machine_csr: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && priv_mode == 2'b00 && csr_addr[9:8] != 2'b00) |-> csr_illegal && csr_rdata == 32'd0);

  a_r12_data_priv_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (data_priv == 2'b11) || (data_priv == 2'b00));
endmodule

bind priv_csr_ctrl priv_csr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
  .trap_take(trap_take), .ecall(ecall), .mret(mret), .priv_mode(priv_mode),
  .data_priv(data_priv), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
  .trap_cause(trap_cause), .mpp_inv_q(mpp_inv_q)
);

// File: tb/priv_csr_ctrl_test.sv
module priv_csr_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_req = 0, csr_we = 0, trap_take = 0, ecall = 0, mret = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [63:0] cycle_cnt = 64'h1234_5678_9ABC_DEF0;
  logic [63:0] instret_cnt = 64'h0000_00AB_0000_0CDE;
  logic [1:0] priv_mode, data_priv;
  logic [31:0] csr_rdata;
  logic csr_illegal, flush_req;
  logic [3:0] trap_cause;
  int compared = 0, mismatched = 0;
  bit done = 0;

  priv_csr_ctrl uut (.*);

  always #5 clk = ~clk;

  // behavioural reference state
  bit m_user = 0, m_mppu = 0, m_mprv = 0, m_cy = 0, m_ir = 0;
  bit [2:0] m_sec = 0;

  task automatic cmp(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit req, bit we, logic [11:0] a, logic [31:0] wd,
                      bit tr, bit ec, bit mr);
    bit ill, known, cnt, gt, trap;
    logic [31:0] rv;
    bit [1:0] cur, mpp;
    @(negedge clk);
    csr_req = req; csr_we = we; csr_addr = a; csr_wdata = wd;
    trap_take = tr; ecall = ec; mret = mr;
    #2;
    cur = m_user ? 2'b00 : 2'b11;
    mpp = m_mppu ? 2'b00 : 2'b11;
    known = 1; cnt = 0; gt = 0; rv = 0;
    case (a)
      12'h300: rv = (32'(m_mprv) << 17) | (32'(mpp) << 11);
      12'h301: rv = 32'h4010_0100;
      12'h306: rv = {29'd0, m_ir, 1'b0, m_cy};
      12'h30A, 12'h31A, 12'h757: rv = 0;
      12'h747: rv = {29'd0, m_sec};
      12'hC00: begin rv = cycle_cnt[31:0];    cnt = 1; gt = m_cy; end
      12'hC80: begin rv = cycle_cnt[63:32];   cnt = 1; gt = m_cy; end
      12'hC02: begin rv = instret_cnt[31:0];  cnt = 1; gt = m_ir; end
      12'hC82: begin rv = instret_cnt[63:32]; cnt = 1; gt = m_ir; end
      default: known = 0;
    endcase
    ill = req && (!known || (we && a[11:10] == 2'b11) || (m_user && a[9:8] != 0) ||
                  (m_user && cnt && !gt));
    if (!req || ill) rv = 0;
    trap = tr || ec;
    cmp(tag, "priv_mode", priv_mode, cur);
    cmp(tag, "data_priv", data_priv, m_mprv ? mpp : cur);
    cmp(tag, "csr_rdata", csr_rdata, rv);
    cmp(tag, "csr_illegal", csr_illegal, ill);
    cmp(tag, "trap_cause", trap_cause, ec ? (m_user ? 8 : 11) : 0);
    cmp(tag, "flush_req", flush_req, trap);
    @(posedge clk);
    #1;
    if (req && we && !ill) begin
      if (a == 12'h300) begin m_mppu = !(wd[12:11] == 2'b11); m_mprv = wd[17]; end
      if (a == 12'h306) begin m_cy = wd[0]; m_ir = wd[2]; end
      if (a == 12'h747) m_sec = wd[2:0];
    end
    if (trap) begin m_mppu = m_user; m_user = 0; end
    else if (mr && !m_user) begin m_user = m_mppu; m_mppu = 1; end
  endtask

  task automatic rd(string tag, logic [11:0] a);  step(tag, 1, 0, a, 0, 0, 0, 0); endtask
  task automatic wr(string tag, logic [11:0] a, logic [31:0] d); step(tag, 1, 1, a, d, 0, 0, 0); endtask

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd("R1", 12'h300); rd("R1", 12'h306); rd("R1", 12'h747);
    // R2 ISA word
    rd("R2", 12'h301); wr("R2", 12'h301, 32'h0); rd("R2", 12'h301);
    // R7 environment configuration pair
    wr("R7", 12'h30A, 32'hFFFF_FFFF); wr("R7", 12'h31A, 32'hFFFF_FFFF);
    rd("R7", 12'h30A); rd("R7", 12'h31A);
    // R11 security configuration
    wr("R11", 12'h747, 32'hFFFF_FFFF); rd("R11", 12'h747);
    wr("R11", 12'h757, 32'hFFFF_FFFF); rd("R11", 12'h757);
    wr("R11", 12'h747, 32'h0000_0005); rd("R11", 12'h747);
    // R9 counter-enable stores bits 0 and 2
    wr("R9", 12'h306, 32'hFFFF_FFFF); rd("R9", 12'h306);
    // R8 counter shadows in machine level, writes illegal
    rd("R8", 12'hC00); rd("R8", 12'hC80); rd("R8", 12'hC02); rd("R8", 12'hC82);
    wr("R8", 12'hC00, 32'h1); wr("R8", 12'hC82, 32'h1);
    // R10 unimplemented address
    rd("R10", 12'h7FF); wr("R10", 12'h123, 32'h5);
    // R3 and R12 status register
    wr("R3", 12'h300, 32'h0002_0000); rd("R12", 12'h300);
    wr("R3", 12'h300, 32'h0002_1000); rd("R3", 12'h300);
    wr("R3", 12'h300, 32'h0002_1800); rd("R12", 12'h300);
    wr("R3", 12'h300, 32'h0000_0000); rd("R3", 12'h300);
    // R5 return to user
    step("R5", 0, 0, 0, 0, 0, 0, 1);
    // R9 user reads with both enables set
    rd("R9", 12'hC00); rd("R9", 12'hC82);
    // R10 user access to machine registers; write must not land
    rd("R10", 12'h300); wr("R10", 12'h306, 32'h0);
    // R8 user write to shadow
    wr("R8", 12'hC02, 32'h0);
    // R5 user mret ignored
    step("R5", 0, 0, 0, 0, 0, 0, 1);
    // R6 user ECALL, R4 trap entry
    step("R6", 0, 0, 0, 0, 0, 1, 0);
    rd("R4", 12'h300); rd("R10", 12'h306);
    // R6 machine ECALL captures machine
    step("R6", 0, 0, 0, 0, 0, 1, 0);
    rd("R4", 12'h300);
    // R5 return to machine, MPP becomes user
    step("R5", 0, 0, 0, 0, 0, 0, 1);
    rd("R5", 12'h300);
    // R9 only instret enabled
    wr("R9", 12'h306, 32'h4);
    step("R5", 0, 0, 0, 0, 0, 0, 1);
    rd("R9", 12'hC00); rd("R9", 12'hC80); rd("R9", 12'hC02); rd("R9", 12'hC82);
    // R4 plain trap in user level, with same-cycle mret
    step("R4", 0, 0, 0, 0, 1, 0, 1);
    rd("R4", 12'h300);
    // R9 cycle enable only
    wr("R9", 12'h306, 32'h1);
    step("R5", 0, 0, 0, 0, 0, 0, 1);
    rd("R9", 12'hC80); rd("R9", 12'hC02);
    // R12 MPRV with user MPP while in machine level
    step("R4", 0, 0, 0, 0, 1, 0, 0);
    wr("R12", 12'h300, 32'h0002_0000); rd("R12", 12'h300);
    step("R1", 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule